// File: doc/BRIEF.md
# I3C Target Dynamic Address Assignment Engine

This block is the target-side logic that lets a device obtain a 7-bit dynamic address from the bus controller on a two-wire I3C bus. It oversamples SCL and SDA with the system clock, recognises START, repeated START and STOP, and pulls SDA low as an open-drain driver. When the controller broadcasts the enter-assignment command, the block waits for the reserved read header. It then offers a 64-bit identity word made of its 48-bit provisional ID, bus characteristics byte and device characteristics byte. It arbitrates bit by bit against any other target, and a driven 0 always beats a released 1.

The target with the lowest identity wins the round. It receives a 7-bit address followed by an odd-parity bit. It acknowledges and keeps the address only when the parity is correct. Once it holds an address it stays out of further assignment until the controller broadcasts the reset-assignment command. That command clears the address and puts the target back into I2C-style operation. A target that loses a round rejoins on the next read header of the same session. A STOP closes the session.

Top module: `i3c_daa_target`

## Requirements
- R1: After reset the target holds no address (valid flag 0, address 0), reports mode 2'b00 (I2C-style) and leaves SDA released.
- R2: The target acknowledges, by pulling SDA low in the ninth bit, every broadcast write header (byte 0xFC: address 0x7E, write bit 0). It acknowledges the broadcast read header (byte 0xFD) only while an assignment session is open and it holds no address.
- R3: After acknowledging the read header, the target sends 64 identity bits, most significant first: provisional ID bits 47..0, then bus characteristics bits 7..0, then device characteristics bits 7..0. A 0 bit pulls SDA low and a 1 bit releases it. No extra bit separates the bytes.
- R4: A target that releases SDA for a 1 and samples 0 stops driving for the rest of that round and does not acknowledge the address byte.
- R5: The address byte carries address bits 6..0, most significant first, followed by a parity bit chosen so that the eight bits hold an odd number of ones. The winner acknowledges in the following bit and latches the address only when the parity is odd. Otherwise it leaves SDA released (NACK) and stays unassigned.
- R6: After a successful assignment the valid flag is 1, the address output shows the latched address and the mode is 2'b01 (I3C SDR). The address does not change while the flag stays set.
- R7: A session opens on command code 0x07, sent after an acknowledged 0xFC header and followed by its T bit, but only if the target holds no address. An assigned target does not acknowledge later read headers and does not drive identity bits.
- R8: Command code 0x06 after a 0xFC header clears the address and the valid flag, closes any session and returns the mode to 2'b00.
- R9: A target that lost a round acknowledges the next 0xFD header of the same session and competes again. After a STOP, a 0xFD header is not acknowledged until a new enter-assignment command.
- R10: The target starts pulling SDA low only while SCL is low. It samples SDA on SCL rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad (wired-AND bus value) |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| pid_i | input | 48 | Provisional ID offered during assignment |
| bcr_i | input | 8 | Bus characteristics byte |
| dcr_i | input | 8 | Device characteristics byte |
| dyn_addr_o | output | 7 | Current dynamic address |
| addr_valid_o | output | 1 | 1 while a dynamic address is held |
| op_mode_o | output | 2 | 2'b00 I2C-style, 2'b01 I3C SDR |

## Verification
The bench models a second target with its own identity on the wired-AND bus. It checks that the lower identity is the one the controller reads back. A design that compared in the wrong sense, or kept driving after a loss, would corrupt that word or acknowledge an address it did not win. Address bytes with wrong parity are mixed into random rounds. A design that ignored parity would latch them, and one with inverted parity would reject good ones. The bench also probes the session edges: a read header after STOP, a second enter-assignment command while assigned, and re-entry after a lost round. A design that leaked session state across STOP, or rejoined while assigned, would acknowledge headers it must leave alone.

// File: rtl/i3c_daa_pkg.sv
package i3c_daa_pkg;

   typedef enum logic [1:0] {
      MODE_I2C = 2'b00,
      MODE_SDR = 2'b01
   } opmode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_CCC,
      ST_ID,
      ST_ADDR,
      ST_AACK,
      ST_SKIP
   } daa_state_e;

   localparam logic [7:0] HDR_BCAST_WR = 8'hFC;
   localparam logic [7:0] HDR_BCAST_RD = 8'hFD;
   localparam logic [7:0] CCC_ENTER    = 8'h07;
   localparam logic [7:0] CCC_RESET    = 8'h06;

endpackage

// File: rtl/i3c_daa_bus_sense.sv
module i3c_daa_bus_sense #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_p,
   output logic stop_p
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("i3c_daa_bus_sense: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] scl_q, sda_q;
   logic                   scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
         sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_s    = scl_q[SYNC_STAGES-1];
   assign sda_s    = sda_q[SYNC_STAGES-1];
   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
   assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i3c_daa_ctrl.sv
module i3c_daa_ctrl
   import i3c_daa_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int ID_W   = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_p,
   input  logic              stop_p,
   input  logic [ID_W-1:0]   identity,
   output logic              sda_pull,
   output logic [ADDR_W-1:0] dyn_addr,
   output logic              addr_valid,
   output opmode_e           op_mode
);

   localparam int BYTE_W = ADDR_W + 1;
   localparam int CNT_W  = $clog2(ID_W + 1);
   localparam logic [CNT_W-1:0] CNT_ACK     = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_ID_LAST = CNT_W'(ID_W - 1);
   localparam logic [CNT_W-1:0] CNT_AD_LAST = CNT_W'(BYTE_W - 1);

   daa_state_e        st;
   logic [CNT_W-1:0]  bcnt;
   logic [BYTE_W-1:0] sh, sh_in;
   logic [ID_W-1:0]   idsh;
   logic              sess, lost, oe, oe_nx, join_ok;

   assign sh_in   = {sh[BYTE_W-2:0], sda_s};
   assign join_ok = sess & ~addr_valid;

   // drive decision for the bit that follows the current SCL fall
   always_comb begin
      case (st)
         ST_HDR:  oe_nx = (bcnt == CNT_ACK) &&
                          ((sh == HDR_BCAST_WR) || ((sh == HDR_BCAST_RD) && join_ok));
         ST_ID:   oe_nx = ~lost & ~idsh[ID_W-1];
         ST_AACK: oe_nx = ~lost & (^sh);
         default: oe_nx = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         bcnt       <= '0;
         sh         <= '0;
         idsh       <= '0;
         sess       <= 1'b0;
         lost       <= 1'b0;
         oe         <= 1'b0;
         dyn_addr   <= '0;
         addr_valid <= 1'b0;
         op_mode    <= MODE_I2C;
      end else if (stop_p) begin
         st   <= ST_IDLE;
         sess <= 1'b0;
         oe   <= 1'b0;
      end else if (start_p) begin
         st   <= ST_HDR;
         bcnt <= '0;
         sh   <= '0;
         oe   <= 1'b0;
      end else if (scl_fall) begin
         oe <= oe_nx;
      end else if (scl_rise) begin
         case (st)
            ST_HDR: begin
               if (bcnt != CNT_ACK) begin
                  sh   <= sh_in;
                  bcnt <= bcnt + CNT_W'(1);
               end else if (sh == HDR_BCAST_WR) begin
                  st   <= ST_CCC;
                  bcnt <= '0;
               end else if ((sh == HDR_BCAST_RD) && join_ok) begin
                  st   <= ST_ID;
                  bcnt <= '0;
                  lost <= 1'b0;
                  idsh <= identity;
               end else begin
                  st <= ST_SKIP;
               end
            end
            ST_CCC: begin
               if (bcnt != CNT_ACK) begin
                  sh   <= sh_in;
                  bcnt <= bcnt + CNT_W'(1);
               end else begin
                  st <= ST_SKIP;
                  if (sh == CCC_ENTER && !addr_valid) sess <= 1'b1;
                  if (sh == CCC_RESET) begin
                     sess       <= 1'b0;
                     addr_valid <= 1'b0;
                     dyn_addr   <= '0;
                     op_mode    <= MODE_I2C;
                  end
               end
            end
            ST_ID: begin
               if (!lost && idsh[ID_W-1] && !sda_s) lost <= 1'b1;
               idsh <= {idsh[ID_W-2:0], 1'b1};
               bcnt <= bcnt + CNT_W'(1);
               if (bcnt == CNT_ID_LAST) begin
                  st   <= ST_ADDR;
                  bcnt <= '0;
               end
            end
            ST_ADDR: begin
               sh   <= sh_in;
               bcnt <= bcnt + CNT_W'(1);
               if (bcnt == CNT_AD_LAST) st <= ST_AACK;
            end
            ST_AACK: begin
               st <= ST_SKIP;
               if (!lost && (^sh)) begin
                  dyn_addr   <= sh[BYTE_W-1:1];
                  addr_valid <= 1'b1;
                  op_mode    <= MODE_SDR;
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_pull = oe;

   a_r10_pull_in_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> !scl_s);
   a_r4_silent_after_loss: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ID && lost) |-> !oe);
   a_r5_ack_needs_parity: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_AACK && oe) |-> ((^sh) && !lost));
   a_r6_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && $past(addr_valid)) |-> $stable(dyn_addr));
   a_r7_no_join_when_valid: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |-> (st != ST_ID));
   a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CCC && scl_rise && !start_p && !stop_p && bcnt == CNT_ACK && sh == CCC_RESET)
      |=> (!addr_valid && op_mode == MODE_I2C));

endmodule

// File: rtl/i3c_daa_target.sv
module i3c_daa_target
   import i3c_daa_pkg::*;
#(
   parameter int PID_W       = 48,
   parameter int CHR_W       = 8,
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull_o,
   input  logic [PID_W-1:0]  pid_i,
   input  logic [CHR_W-1:0]  bcr_i,
   input  logic [CHR_W-1:0]  dcr_i,
   output logic [ADDR_W-1:0] dyn_addr_o,
   output logic              addr_valid_o,
   output logic [1:0]        op_mode_o
);

   localparam int ID_W = PID_W + 2 * CHR_W;

   if (ADDR_W != 7) begin : g_bad_addr
      $error("i3c_daa_target: the address byte format needs ADDR_W == 7");
   end
   if (ID_W < 2) begin : g_bad_id
      $error("i3c_daa_target: identity word too short");
   end

   logic    scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
   opmode_e mode;

   i3c_daa_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_p  (start_p),
      .stop_p   (stop_p)
   );

   i3c_daa_ctrl #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_s      (scl_s),
      .sda_s      (sda_s),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_p    (start_p),
      .stop_p     (stop_p),
      .identity   ({pid_i, bcr_i, dcr_i}),
      .sda_pull   (sda_pull_o),
      .dyn_addr   (dyn_addr_o),
      .addr_valid (addr_valid_o),
      .op_mode    (mode)
   );

   assign op_mode_o = mode;

   a_r1_mode_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid_o ? (op_mode_o == 2'b01) : (op_mode_o == 2'b00));

endmodule

// File: tb/i3c_daa_target_tb.sv
module i3c_daa_target_tb;

   localparam int CLK_P = 10;
   localparam int Q     = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        ctl_low = 1'b0;
   logic        oth_low = 1'b0;
   logic [47:0] pid = 48'h0;
   logic [7:0]  bcr = 8'h0;
   logic [7:0]  dcr = 8'h0;
   logic        dut_pull;
   logic [6:0]  dyn_addr;
   logic        addr_valid;
   logic [1:0]  op_mode;
   wire         sda_bus = ~(ctl_low | dut_pull | oth_low);

   int checks = 0;
   int errors = 0;
   int scl_high_pulls = 0;
   logic prev_pull = 1'b0;

   i3c_daa_target u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_i        (scl),
      .sda_i        (sda_bus),
      .sda_pull_o   (dut_pull),
      .pid_i        (pid),
      .bcr_i        (bcr),
      .dcr_i        (dcr),
      .dyn_addr_o   (dyn_addr),
      .addr_valid_o (addr_valid),
      .op_mode_o    (op_mode)
   );

   always #(CLK_P/2) clk = ~clk;

   // R10 monitor: SDA pull may only begin while SCL is low
   always @(negedge clk) begin
      if (dut_pull && !prev_pull && scl) scl_high_pulls++;
      prev_pull <= dut_pull;
   end

   function automatic logic [63:0] dut_id();
      return {pid, bcr, dcr};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bitc(input bit low, input bit olow, output bit seen);
      wq(); ctl_low = low; oth_low = olow;
      wq(); scl = 1'b1;
      wq(); seen = sda_bus;
      wq(); scl = 1'b0;
   endtask

   task automatic start_c();
      if (scl) begin
         wq(); ctl_low = 1'b1;
         wq(); scl = 1'b0;
      end else begin
         wq(); ctl_low = 1'b0; oth_low = 1'b0;
         wq(); scl = 1'b1;
         wq(); ctl_low = 1'b1;
         wq(); scl = 1'b0;
      end
   endtask

   task automatic stop_c();
      wq(); ctl_low = 1'b1; oth_low = 1'b0;
      wq(); scl = 1'b1;
      wq(); ctl_low = 1'b0;
      wq();
   endtask

   task automatic wr_byte(input logic [7:0] b, output bit ack);
      bit s;
      for (int i = 7; i >= 0; i--) bitc(!b[i], 1'b0, s);
      bitc(1'b0, 1'b0, s);
      ack = !s;
   endtask

   task automatic ccc(input logic [7:0] code);
      bit a, s;
      wr_byte(8'hFC, a);
      chk(a, "R2 broadcast write header ack", {63'h0, a}, 64'h1);
      for (int i = 7; i >= 0; i--) bitc(!code[i], 1'b0, s);
      bitc(!(~^code), 1'b0, s);
   endtask

   task automatic round(input bit oth_in, input logic [63:0] oid, input logic [6:0] a,
                        input bit badp, output bit hack, output logic [63:0] seen_id,
                        output bit aack);
      bit s, olost, ol, p;
      logic [7:0] ab;
      start_c();
      wr_byte(8'hFD, hack);
      olost = 1'b0;
      for (int i = 63; i >= 0; i--) begin
         ol = oth_in && !olost && !oid[i];
         bitc(1'b0, ol, s);
         seen_id[i] = s;
         if (oth_in && !olost && oid[i] && !s) olost = 1'b1;
      end
      p  = (~^a) ^ badp;
      ab = {a, p};
      for (int i = 7; i >= 0; i--) bitc(!ab[i], 1'b0, s);
      bitc(1'b0, 1'b0, s);
      aack = !s;
   endtask

   task automatic finish_up();
      chk(scl_high_pulls == 0, "R10 pull started with SCL high", scl_high_pulls, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      bit          hack, aack, wins, badp, oin;
      logic [63:0] sid, oid, exp_id;
      logic [6:0]  a;
      int unsigned seed;
      seed = $urandom(32'd20240611);

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(addr_valid == 1'b0, "R1 valid after reset", addr_valid, 0);
      chk(op_mode == 2'b00, "R1 mode after reset", op_mode, 0);
      chk(dut_pull == 1'b0, "R1 SDA released after reset", dut_pull, 0);
      chk(dyn_addr == 7'h0, "R1 address after reset", dyn_addr, 0);

      // directed: single target, good parity
      pid = 48'h0208_1381_0100; bcr = 8'h27; dcr = 8'hA0;
      start_c(); ccc(8'h07);
      round(1'b0, '1, 7'h2A, 1'b0, hack, sid, aack);
      chk(hack, "R2 read header ack in session", hack, 1);
      chk(sid == dut_id(), "R3 identity order", sid, dut_id());
      chk(aack, "R5 address ack good parity", aack, 1);
      stop_c();
      chk(addr_valid && dyn_addr == 7'h2A, "R6 address latched", {addr_valid, dyn_addr}, {1'b1, 7'h2A});
      chk(op_mode == 2'b01, "R6 mode SDR", op_mode, 1);

      // R7: assigned target ignores a new session
      start_c(); ccc(8'h07);
      round(1'b0, '1, 7'h11, 1'b0, hack, sid, aack);
      chk(!hack, "R7 no header ack when assigned", hack, 0);
      chk(sid == '1, "R7 no identity driven", sid, '1);
      chk(!aack, "R7 no address ack", aack, 0);
      stop_c();
      chk(dyn_addr == 7'h2A && addr_valid, "R7 address kept", dyn_addr, 7'h2A);

      // R8: reset command
      start_c(); ccc(8'h06); stop_c();
      chk(!addr_valid && op_mode == 2'b00, "R8 cleared by reset command", {addr_valid, op_mode}, 0);

      // R5 bad parity, then R9 rejoin in same session
      start_c(); ccc(8'h07);
      round(1'b0, '1, 7'h33, 1'b1, hack, sid, aack);
      chk(!aack, "R5 NACK on even parity", aack, 1'b0);
      chk(!addr_valid, "R5 no latch on even parity", addr_valid, 0);
      round(1'b0, '1, 7'h33, 1'b0, hack, sid, aack);
      chk(hack && aack && dyn_addr == 7'h33, "R9 second round in session", {hack, aack, dyn_addr}, {2'b11, 7'h33});
      stop_c();

      // R9: STOP closes the session
      start_c(); ccc(8'h06); stop_c();
      start_c(); ccc(8'h07); stop_c();
      start_c(); wr_byte(8'hFD, hack); stop_c();
      chk(!hack, "R9 read header after STOP", hack, 0);

      // R4: lower competitor wins, then R9 rejoin
      oid = dut_id() & ~(64'h1 << 40);
      if (oid == dut_id()) oid = dut_id() & ~(64'h1 << 45);
      start_c(); ccc(8'h07);
      round(1'b1, oid, 7'h05, 1'b0, hack, sid, aack);
      chk(sid == oid, "R4 lower identity wins", sid, oid);
      chk(!aack && !addr_valid, "R4 loser does not take address", {aack, addr_valid}, 0);
      round(1'b0, '1, 7'h05, 1'b0, hack, sid, aack);
      chk(hack && aack, "R9 loser rejoins", {hack, aack}, 2'b11);
      stop_c();

      // constrained random rounds
      for (int it = 0; it < 12; it++) begin
         pid = {16'($urandom), $urandom};
         bcr = 8'($urandom);
         dcr = 8'($urandom);
         oid = {$urandom, $urandom};
         if (oid == dut_id()) oid = ~oid;
         oin  = ($urandom % 2) == 0;
         a    = 7'($urandom);
         badp = ($urandom % 4) == 0;
         wins = !oin || (dut_id() < oid);
         exp_id = oin ? ((dut_id() < oid) ? dut_id() : oid) : dut_id();
         start_c(); ccc(8'h06); stop_c();
         chk(!addr_valid, "R8 random reset command", addr_valid, 0);
         start_c(); ccc(8'h07);
         round(oin, oid, a, badp, hack, sid, aack);
         stop_c();
         chk(hack, "R2 random header ack", hack, 1);
         chk(sid == exp_id, "R3 R4 random identity", sid, exp_id);
         chk(aack == (wins && !badp), "R5 random address ack", aack, wins && !badp);
         chk(addr_valid == (wins && !badp), "R6 random valid", addr_valid, wins && !badp);
         if (wins && !badp)
            chk(dyn_addr == a && op_mode == 2'b01, "R6 random address", dyn_addr, a);
      end

      finish_up();
   end

endmodule